// File: doc/BRIEF.md
# Sign-Mode Sequential Divider

This block is a multi-cycle 32-bit integer divider for the execute stage of a RISC-V style pipeline. A request presents a numerator, a denominator, a two-bit sign mode, a select that picks the quotient or the remainder, and the current program counter. The unit prepares the operands for the chosen sign mode and runs an unsigned restoring division that retires one quotient bit per clock. It then puts the sign back on the chosen result and returns one 32-bit value with a single-cycle `done` pulse.

Three sign modes are defined. Mode 0 is plain unsigned division. Mode 1 is signed division with two's-complement operands and truncation toward zero. Mode 2 inverts a negative numerator bit by bit, divides it unsigned, and inverts the result again, which gives floor division as used for arithmetic-shift-style division. Mode 3 is not used and behaves as mode 0. Along with the result, the unit gives writeback control: a register write, no memory store, and a next PC four bytes past the PC captured with the request.

Top module: `sdm_divider`

## Requirements
- R1: In sign mode 0 both operands are unsigned. The result is the unsigned quotient (`want_rem`=0) or the unsigned remainder (`want_rem`=1).
- R2: In sign mode 1 both operands are two's complement. The quotient truncates toward zero and is negated when exactly one operand is negative. The remainder takes the sign of the numerator.
- R3: In sign mode 2 the denominator is unsigned. A numerator with bit 31 set is replaced by its bitwise inverse before the division, and the selected result is then bitwise inverted. This gives quotient = floor(n/d) and remainder = -1 - ((~n) mod d).
- R4: Sign mode 3 gives the same results as sign mode 0.
- R5: When the denominator is zero (both 16-bit halves zero), the quotient is 0xFFFFFFFF in every sign mode.
- R6: When the denominator is zero, the remainder equals the original numerator in every sign mode.
- R7: In sign mode 1, 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R8: A start seen while idle is accepted, and `busy` then stays high. `done` rises exactly 32 clock edges after the accepting edge, lasts one cycle, and `busy` is low while `done` is high.
- R9: A start pulse while `busy` is high is ignored. The running operation completes with its own operands and timing.
- R10: In the `done` cycle `reg_write` is 1 and `next_pc` equals the captured `pc_in` plus 4. `reg_write` is 0 in every other cycle, and `mem_store` is always 0.
- R11: After reset, `busy`, `done` and `reg_write` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| numer | input | 32 | Numerator |
| denom | input | 32 | Denominator |
| sign_mode | input | 2 | 0 unsigned, 1 two's complement, 2 ones'-complement numerator, 3 as 0 |
| want_rem | input | 1 | 1 selects the remainder, 0 the quotient |
| pc_in | input | 32 | Program counter of the request |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Sign-restored quotient or remainder, valid with `done` |
| reg_write | output | 1 | Register writeback enable, high with `done` |
| mem_store | output | 1 | Memory store enable, always low |
| next_pc | output | 32 | Captured PC plus 4, valid with `done` |

## Verification
Two cases are hard to reach: a start pulse that arrives while a division is under way, and the sign corner cases where a flag must be suppressed. For the first, the bench issues a second request with different operands in the middle of a division. It then checks that the result and the latency belong to the first request only. For the second, the bench runs dedicated operand pairs: a zero denominator with a negative numerator in each sign mode, where the quotient must not be negated and the remainder must come back unchanged, and the most negative value divided by -1. The expected results come from a model built on plain `/` and `%` operators.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [1:0] {
    SM_UNSIGNED = 2'd0,
    SM_TWOS     = 2'd1,
    SM_ONES     = 2'd2,
    SM_SPARE    = 2'd3
  } sign_mode_e;

  // Mode 3 is folded onto unsigned division.
  function automatic sign_mode_e fold_mode(input logic [1:0] raw);
    sign_mode_e m;
    m = sign_mode_e'(raw);
    if (m == SM_SPARE) m = SM_UNSIGNED;
    return m;
  endfunction
endpackage

// File: rtl/sdm_precond.sv
module sdm_precond
  import sdm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] numer_raw,
  input  logic [W-1:0] denom_raw,
  input  sign_mode_e   mode,
  output logic [W-1:0] numer_mag,
  output logic [W-1:0] denom_mag,
  output logic         neg_numer,
  output logic         neg_denom,
  output logic         denom_zero
);
  localparam int HW = W / 2;

  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] v);
    return (~v) + W'(1);
  endfunction

  always_comb begin
    numer_mag = numer_raw;
    denom_mag = denom_raw;
    neg_numer = 1'b0;
    neg_denom = 1'b0;
    unique case (mode)
      SM_TWOS: begin
        neg_numer = numer_raw[W-1];
        neg_denom = denom_raw[W-1];
        if (neg_numer) numer_mag = twos_neg(numer_raw);
        if (neg_denom) denom_mag = twos_neg(denom_raw);
      end
      SM_ONES: begin
        neg_numer = numer_raw[W-1];
        if (neg_numer) numer_mag = ~numer_raw;
      end
      default: ;
    endcase
  end

  // Zero test split over the two halves of the (conditioned) denominator.
  assign denom_zero = (denom_mag[HW-1:0] == '0) && (denom_mag[W-1:HW] == '0);
endmodule

// File: rtl/sdm_core.sv
module sdm_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         running,
  output logic         finish,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, trial;
  logic [W-1:0]  rem_nx, quo_nx;

  // One restoring step: shift in the next dividend bit, try to subtract.
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    rem_nx  = trial[W] ? shifted[W-1:0] : trial[W-1:0];
    quo_nx  = {quo_q[W-2:0], ~trial[W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      running <= 1'b0;
      finish  <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (!running) begin
        if (load) begin
          rem_q   <= '0;
          quo_q   <= dividend;
          dvs_q   <= divisor;
          cnt_q   <= '0;
          running <= 1'b1;
        end
      end else begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          running <= 1'b0;
          finish  <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/sdm_postfix.sv
module sdm_postfix
  import sdm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  sign_mode_e   mode,
  input  logic         pick_rem,
  input  logic         neg_numer,
  input  logic         neg_denom,
  input  logic         denom_zero,
  output logic         neg_out,
  output logic [W-1:0] value
);
  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] v,
                                               input sign_mode_e m,
                                               input logic neg);
    logic [W-1:0] r;
    r = v;
    if (neg) begin
      if (m == SM_TWOS)      r = (~v) + W'(1);
      else if (m == SM_ONES) r = ~v;
    end
    return r;
  endfunction

  logic [W-1:0] picked;

  always_comb begin
    if (pick_rem) begin
      picked  = rem_mag;
      neg_out = (mode == SM_UNSIGNED) ? 1'b0 : neg_numer;
    end else begin
      picked  = quo_mag;
      neg_out = (neg_numer ^ neg_denom) & ~denom_zero;
    end
    value = apply_sign(picked, mode, neg_out);
  end
endmodule

// File: rtl/sdm_divider.sv
module sdm_divider
  import sdm_pkg::*;
#(
  parameter int W  = 32,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  numer,
  input  logic [W-1:0]  denom,
  input  logic [1:0]    sign_mode,
  input  logic          want_rem,
  input  logic [PW-1:0] pc_in,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result,
  output logic          reg_write,
  output logic          mem_store,
  output logic [PW-1:0] next_pc
);
  localparam logic [PW-1:0] PC_STEP = PW'(4);

  sign_mode_e   mode_in, mode_q;
  logic [W-1:0] numer_mag, denom_mag, core_quo, core_rem;
  logic         neg_numer_c, neg_denom_c, denom_zero_c;
  logic         neg_numer_q, neg_denom_q, denom_zero_q, pick_rem_q;
  logic         neg_out;
  logic [PW-1:0] pc_q;
  logic         accept;

  assign mode_in = fold_mode(sign_mode);
  assign accept  = start & ~busy;

  sdm_precond #(.W(W)) u_pre (
    .numer_raw (numer),
    .denom_raw (denom),
    .mode      (mode_in),
    .numer_mag (numer_mag),
    .denom_mag (denom_mag),
    .neg_numer (neg_numer_c),
    .neg_denom (neg_denom_c),
    .denom_zero(denom_zero_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= SM_UNSIGNED;
      neg_numer_q  <= 1'b0;
      neg_denom_q  <= 1'b0;
      denom_zero_q <= 1'b0;
      pick_rem_q   <= 1'b0;
      pc_q         <= '0;
    end else if (accept) begin
      mode_q       <= mode_in;
      neg_numer_q  <= neg_numer_c;
      neg_denom_q  <= neg_denom_c;
      denom_zero_q <= denom_zero_c;
      pick_rem_q   <= want_rem;
      pc_q         <= pc_in;
    end
  end

  sdm_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .dividend(numer_mag),
    .divisor (denom_mag),
    .running (busy),
    .finish  (done),
    .quo     (core_quo),
    .rem     (core_rem)
  );

  sdm_postfix #(.W(W)) u_post (
    .quo_mag   (core_quo),
    .rem_mag   (core_rem),
    .mode      (mode_q),
    .pick_rem  (pick_rem_q),
    .neg_numer (neg_numer_q),
    .neg_denom (neg_denom_q),
    .denom_zero(denom_zero_q),
    .neg_out   (neg_out),
    .value     (result)
  );

  assign reg_write = done;
  assign mem_store = 1'b0;
  assign next_pc   = pc_q + PC_STEP;
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         reg_write,
  input logic [W-1:0] result,
  input logic [1:0]   sign_mode,
  input logic         neg_numer_c,
  input logic         neg_denom_c,
  input logic         denom_zero_q,
  input logic         pick_rem_q,
  input logic         neg_out
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_ends_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> (busy || done));

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_wb_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_write |-> done);

  assert_unsigned_noflags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sign_mode == 2'd0) |-> (!neg_numer_c && !neg_denom_c));

  assert_div0_quot_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && denom_zero_q && !pick_rem_q) |-> (result == {W{1'b1}} && !neg_out));
endmodule

bind sdm_divider sdm_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .reg_write   (reg_write),
  .result      (result),
  .sign_mode   (sign_mode),
  .neg_numer_c (neg_numer_c),
  .neg_denom_c (neg_denom_c),
  .denom_zero_q(denom_zero_q),
  .pick_rem_q  (pick_rem_q),
  .neg_out     (neg_out)
);

// File: tb/tb_sdm_divider.sv
module tb_sdm_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] numer = '0, denom = '0, pc_in = '0;
  logic [1:0]  sign_mode = '0;
  logic        want_rem = 1'b0;
  logic        busy, done, reg_write, mem_store;
  logic [31:0] result, next_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdm_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .numer(numer), .denom(denom),
    .sign_mode(sign_mode), .want_rem(want_rem), .pc_in(pc_in),
    .busy(busy), .done(done), .result(result), .reg_write(reg_write),
    .mem_store(mem_store), .next_pc(next_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  function automatic logic [31:0] model(input logic [31:0] n, input logic [31:0] d,
                                        input logic [1:0] m, input logic r);
    logic signed [63:0] sn, sd;
    logic [31:0] q, rr, inv;
    if (d == 0) return r ? n : 32'hFFFF_FFFF;           // R5, R6
    if (m == 2'd1) begin                                  // R2, R7
      if (n == 32'h8000_0000 && d == 32'hFFFF_FFFF) return r ? 32'h0 : 32'h8000_0000;
      sn = 64'(signed'(n));
      sd = 64'(signed'(d));
      return r ? 32'(sn % sd) : 32'(sn / sd);
    end
    if (m == 2'd2 && n[31]) begin                         // R3
      inv = ~n;
      q = inv / d;
      rr = inv % d;
      return r ? (32'hFFFF_FFFF - rr) : (32'hFFFF_FFFF - q);
    end
    return r ? n % d : n / d;                             // R1, R4
  endfunction

  task automatic run_op(input string tag, input logic [31:0] n, input logic [31:0] d,
                        input logic [1:0] m, input logic r, input logic [31:0] pc,
                        input bit poke_busy);
    int lat;
    @(negedge clk);
    numer = n; denom = d; sign_mode = m; want_rem = r; pc_in = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      if (poke_busy && lat == 5) begin                    // R9 stimulus
        numer = 32'h1234_5678; denom = 32'h3; sign_mode = 2'd0;
        want_rem = ~r; pc_in = 32'hDEAD_0000; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({tag, " result"}, result, model(n, d, m, r));
    check("R8 latency", 32'(lat), 32'd32);
    check("R8 busy low at done", {31'd0, busy}, 32'd0);
    check("R10 reg_write", {31'd0, reg_write}, 32'd1);
    check("R10 mem_store", {31'd0, mem_store}, 32'd0);
    check("R10 next_pc", next_pc, pc + 32'd4);
    @(negedge clk);
    check("R8 done one cycle", {31'd0, done}, 32'd0);
    check("R10 reg_write after", {31'd0, reg_write}, 32'd0);
  endtask

  task automatic t_reset;
    check("R11 busy", {31'd0, busy}, 32'd0);
    check("R11 done", {31'd0, done}, 32'd0);
    check("R11 reg_write", {31'd0, reg_write}, 32'd0);
  endtask

  task automatic t_mode0;
    run_op("R1 q", 32'd100, 32'd7, 2'd0, 1'b0, 32'h100, 0);
    run_op("R1 r", 32'd100, 32'd7, 2'd0, 1'b1, 32'h104, 0);
    run_op("R1 big", 32'hFFFF_FFF0, 32'h8000_0001, 2'd0, 1'b0, 32'h108, 0);
    check("R1 const", model(32'hFFFF_FFF0, 32'h8000_0001, 2'd0, 1'b1), 32'h7FFF_FFEF);
  endtask

  task automatic t_mode1;
    run_op("R2 q neg/pos", 32'hFFFF_FF9C, 32'd7, 2'd1, 1'b0, 32'h200, 0);
    run_op("R2 r neg/pos", 32'hFFFF_FF9C, 32'd7, 2'd1, 1'b1, 32'h204, 0);
    run_op("R2 q pos/neg", 32'd100, 32'hFFFF_FFF9, 2'd1, 1'b0, 32'h208, 0);
    run_op("R2 r neg/neg", 32'hFFFF_FF9C, 32'hFFFF_FFF9, 2'd1, 1'b1, 32'h20C, 0);
    check("R2 const", model(32'hFFFF_FF9C, 32'd7, 2'd1, 1'b0), 32'hFFFF_FFF2);
  endtask

  task automatic t_mode2;
    run_op("R3 q", 32'hFFFF_FFF9, 32'd2, 2'd2, 1'b0, 32'h300, 0);
    run_op("R3 r", 32'hFFFF_FFF9, 32'd2, 2'd2, 1'b1, 32'h304, 0);
    run_op("R3 q pos", 32'd9, 32'd4, 2'd2, 1'b0, 32'h308, 0);
    run_op("R3 q neg denom unsigned", 32'hFFFF_0000, 32'h8000_0000, 2'd2, 1'b0, 32'h30C, 0);
    check("R3 const floor", model(32'hFFFF_FFF9, 32'd2, 2'd2, 1'b0), 32'hFFFF_FFFC);
  endtask

  task automatic t_mode3;
    run_op("R4 q", 32'hFFFF_FF9C, 32'd7, 2'd3, 1'b0, 32'h400, 0);
    run_op("R4 r", 32'hFFFF_FF9C, 32'd7, 2'd3, 1'b1, 32'h404, 0);
  endtask

  task automatic t_div0;
    for (int m = 0; m < 4; m++) begin
      run_op("R5 q div0", 32'hF000_0005, 32'd0, 2'(m), 1'b0, 32'h500, 0);
      run_op("R6 r div0", 32'hF000_0005, 32'd0, 2'(m), 1'b1, 32'h504, 0);
    end
  endtask

  task automatic t_overflow;
    run_op("R7 q ovf", 32'h8000_0000, 32'hFFFF_FFFF, 2'd1, 1'b0, 32'h600, 0);
    run_op("R7 r ovf", 32'h8000_0000, 32'hFFFF_FFFF, 2'd1, 1'b1, 32'h604, 0);
  endtask

  task automatic t_busy_ignore;
    run_op("R9 ignored start", 32'd1000, 32'd33, 2'd0, 1'b0, 32'h700, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_div0();
    t_overflow();
    t_busy_ignore();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule